// File: doc/BRIEF.md
# Byte-to-Word IDE Lane Steering Bridge

The bridge sits between an 8-bit host bus and a 16-bit IDE data bus. Every drive access is a full 16-bit transfer. A holding byte keeps the half of the word that the host is not moving at that moment.

A host read at an even address runs a drive read cycle. It returns the low byte and keeps the high byte in the holding byte. A host read at an odd address does not touch the drive and returns the holding byte. Writes work the other way round:
- A write at an even address only loads the holding byte.
- A write at an odd address runs a drive write cycle. The host byte goes on the lower lanes and the holding byte on the upper lanes.

The IDE register index is the host address shifted down one bit, so the data register takes a two-byte slot and the other registers keep their natural order.

Requests arrive on a valid/ready channel. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` stays low from acceptance until the drive cycle has finished. For a read, it also stays low until the response has been taken. Read responses leave on a valid/ready channel. `rsp_valid` and `rsp_data` hold steady until `rsp_ready` is seen high. Writes produce no response.

Top module: `ide_lane_bridge`

## Requirements
- R1: After reset:
  - the holding byte is 0x00;
  - `ide_cs_n`, `ide_rd_n` and `ide_wr_n` are high;
  - `ide_d_oe` is low;
  - `req_ready` is high and `rsp_valid` is low.
- R2: A read with `req_addr[0]`=0 produces one `ide_rd_n` low pulse of exactly `PULSE_CLKS` cycles with `ide_cs_n` low. The response is bits [7:0] of `ide_d_in` as sampled on the last cycle of that pulse.
- R3: The same drive read stores bits [15:8] of `ide_d_in` in the holding byte. A byte left unread is replaced by the next even read.
- R4: A read with `req_addr[0]`=1 produces no drive strobe. It returns the holding byte in the cycle after acceptance and leaves the holding byte unchanged.
- R5: A write with `req_addr[0]`=0 loads `req_wdata` into the holding byte. It produces no strobe and no response.
- R6: A write with `req_addr[0]`=1 produces one `ide_wr_n` low pulse of `PULSE_CLKS` cycles with `ide_cs_n` low. During the pulse `ide_d_out` is {holding byte, `req_wdata`}, stable, and `ide_d_oe` is high exactly while `ide_wr_n` is low.
- R7: `ide_rd_n` and `ide_wr_n` are never low together. Neither is low unless `ide_cs_n` is low.
- R8: For every drive cycle, `ide_addr` equals `req_addr[HOST_AW-1:1]` of the triggering request and stays stable while `ide_cs_n` is low.
- R9: `req_ready` is low while a drive cycle runs and while a response waits. A response held back by `rsp_ready` low keeps `rsp_valid` high and `rsp_data` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | HOST_AW | Host byte address; bit 0 selects lane |
| req_wdata | input | 8 | Host write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Read response byte |
| ide_addr | output | HOST_AW-1 | IDE register index |
| ide_cs_n | output | 1 | Drive chip select, active low |
| ide_rd_n | output | 1 | Drive read strobe, active low |
| ide_wr_n | output | 1 | Drive write strobe, active low |
| ide_d_in | input | 16 | Data lanes from the drive |
| ide_d_out | output | 16 | Data lanes to the drive |
| ide_d_oe | output | 1 | Output enable for the data lanes |

## Verification
Request sequences cover the following, and each pattern separates a different wrong steering choice:
- Even and odd reads in pairs show whether the high lane is captured and replayed rather than refetched from the drive.
- An odd read straight after reset shows the cleared holding byte.
- Two even reads in a row without an odd read show that a stale high byte is replaced.
- An even write followed by an odd write shows that the upper lanes come from the holding byte and the lower lanes from the triggering byte. Strobe counts stay flat across an even write.
- Drive words with distinct bytes and odd addresses at the top of the range expose swapped lanes and a wrong address shift.
- Holding `rsp_ready` low separates a held response from one that is dropped or changes.

// File: rtl/ide_steer_pkg.sv
package ide_steer_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PULSE = 2'd1,
    PH_REPLY = 2'd2
  } phase_t;
endpackage

// File: rtl/ide_addr_map.sv
module ide_addr_map #(
  parameter int REG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] upper_addr,
  output logic [REG_W-1:0] reg_idx
);
  // Host A0 picks the byte lane; the register index starts at host A1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    reg_idx <= '0;
    else if (load) reg_idx <= upper_addr;
  end
endmodule

// File: rtl/ide_strobe_seq.sv
module ide_strobe_seq
  import ide_steer_pkg::*;
#(
  parameter int PULSE_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_rd,
  input  logic start_wr,
  input  logic start_local,
  input  logic rsp_ready,
  output logic idle,
  output logic reply,
  output logic rd_act,
  output logic wr_act,
  output logic capture
);
  localparam int CNT_W = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_CLKS - 1);

  phase_t           phase_q;
  logic             is_wr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      is_wr_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_rd || start_wr) begin
            phase_q <= PH_PULSE;
            is_wr_q <= start_wr;
            cnt_q   <= CNT_LAST;
          end else if (start_local) begin
            phase_q <= PH_REPLY;
          end
        end
        PH_PULSE: begin
          if (cnt_q == '0) phase_q <= is_wr_q ? PH_IDLE : PH_REPLY;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        PH_REPLY: begin
          if (rsp_ready) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    idle    = (phase_q == PH_IDLE);
    reply   = (phase_q == PH_REPLY);
    rd_act  = (phase_q == PH_PULSE) && !is_wr_q;
    wr_act  = (phase_q == PH_PULSE) &&  is_wr_q;
    capture = rd_act && (cnt_q == '0);
  end
endmodule

// File: rtl/ide_lane_path.sv
module ide_lane_path #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_load,
  input  logic              wr_start,
  input  logic              capture,
  input  logic              local_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic [2*BYTE_W-1:0] drive_din,
  output logic [2*BYTE_W-1:0] drive_dout,
  output logic [BYTE_W-1:0] rsp_byte
);
  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] low_q;
  logic [BYTE_W-1:0] rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      low_q  <= '0;
      rsp_q  <= '0;
    end else begin
      if (hold_load) hold_q <= host_wdata;
      if (wr_start)  low_q  <= host_wdata;
      if (capture) begin
        rsp_q  <= drive_din[BYTE_W-1:0];
        hold_q <= drive_din[2*BYTE_W-1:BYTE_W];
      end
      if (local_rd)  rsp_q  <= hold_q;
    end
  end

  assign drive_dout = {hold_q, low_q};
  assign rsp_byte   = rsp_q;
endmodule

// File: rtl/ide_lane_bridge.sv
module ide_lane_bridge #(
  parameter int HOST_AW    = 4,
  parameter int PULSE_CLKS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [HOST_AW-1:0]   req_addr,
  input  logic [7:0]           req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [7:0]           rsp_data,
  output logic [HOST_AW-2:0]   ide_addr,
  output logic                 ide_cs_n,
  output logic                 ide_rd_n,
  output logic                 ide_wr_n,
  input  logic [15:0]          ide_d_in,
  output logic [15:0]          ide_d_out,
  output logic                 ide_d_oe
);
  localparam int REG_W = HOST_AW - 1;

  logic accept, odd;
  logic start_rd, start_wr, start_local, hold_load;
  logic idle, reply, rd_act, wr_act, capture;

  assign accept      = req_valid && idle;
  assign odd         = req_addr[0];
  assign start_rd    = accept && !req_write && !odd;
  assign start_local = accept && !req_write &&  odd;
  assign start_wr    = accept &&  req_write &&  odd;
  assign hold_load   = accept &&  req_write && !odd;

  ide_addr_map #(.REG_W(REG_W)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_rd || start_wr),
    .upper_addr (req_addr[HOST_AW-1:1]),
    .reg_idx    (ide_addr)
  );

  ide_strobe_seq #(.PULSE_CLKS(PULSE_CLKS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_rd    (start_rd),
    .start_wr    (start_wr),
    .start_local (start_local),
    .rsp_ready   (rsp_ready),
    .idle        (idle),
    .reply       (reply),
    .rd_act      (rd_act),
    .wr_act      (wr_act),
    .capture     (capture)
  );

  ide_lane_path #(.BYTE_W(8)) u_lane (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_load  (hold_load),
    .wr_start   (start_wr),
    .capture    (capture),
    .local_rd   (start_local),
    .host_wdata (req_wdata),
    .drive_din  (ide_d_in),
    .drive_dout (ide_d_out),
    .rsp_byte   (rsp_data)
  );

  assign req_ready = idle;
  assign rsp_valid = reply;
  assign ide_cs_n  = !(rd_act || wr_act);
  assign ide_rd_n  = !rd_act;
  assign ide_wr_n  = !wr_act;
  assign ide_d_oe  = wr_act;
endmodule

// File: rtl/ide_lane_bridge_chk.sv
module ide_lane_bridge_chk #(
  parameter int HOST_AW    = 4,
  parameter int PULSE_CLKS = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [7:0]         rsp_data,
  input logic [HOST_AW-2:0] ide_addr,
  input logic               ide_cs_n,
  input logic               ide_rd_n,
  input logic               ide_wr_n,
  input logic [15:0]        ide_d_out,
  input logic               ide_d_oe
);
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     low_run <= '0;
    else if (!ide_rd_n || !ide_wr_n) low_run <= low_run + 16'd1;
    else                            low_run <= '0;
  end

  always @(posedge clk) begin
    if (!rst_n)
      assert_reset_idle_R1: assert (ide_cs_n && ide_rd_n && ide_wr_n && !ide_d_oe && !rsp_valid);
  end

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_rd_n && !ide_wr_n));
  assert_strobe_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_rd_n || !ide_wr_n) |-> !ide_cs_n);
  assert_oe_during_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ide_d_oe |-> !ide_wr_n);
  assert_write_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ide_wr_n |-> ide_d_oe);
  assert_dout_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_wr_n && $past(!ide_wr_n)) |-> $stable(ide_d_out));
  assert_pulse_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run != 16'd0 && ide_rd_n && ide_wr_n) |-> (low_run == 16'(PULSE_CLKS)));
  assert_pulse_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_rd_n || !ide_wr_n) |-> (low_run < 16'(PULSE_CLKS)));
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_cs_n && $past(!ide_cs_n)) |-> $stable(ide_addr));
  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_cs_n || rsp_valid) |-> !req_ready);
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind ide_lane_bridge ide_lane_bridge_chk #(.HOST_AW(HOST_AW), .PULSE_CLKS(PULSE_CLKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .ide_addr  (ide_addr),
  .ide_cs_n  (ide_cs_n),
  .ide_rd_n  (ide_rd_n),
  .ide_wr_n  (ide_wr_n),
  .ide_d_out (ide_d_out),
  .ide_d_oe  (ide_d_oe)
);

// File: tb/test_ide_lane_bridge.sv
`timescale 1ns/1ps
module test_ide_lane_bridge;
  localparam int AW = 4;
  localparam int PC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [15:0] ide_d_in = '0;
  logic req_ready, rsp_valid, ide_cs_n, ide_rd_n, ide_wr_n, ide_d_oe;
  logic [7:0] rsp_data;
  logic [AW-2:0] ide_addr;
  logic [15:0] ide_d_out;

  always #4 clk = ~clk;

  ide_lane_bridge #(.HOST_AW(AW), .PULSE_CLKS(PC)) i_ide_lane_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ide_addr(ide_addr), .ide_cs_n(ide_cs_n), .ide_rd_n(ide_rd_n),
    .ide_wr_n(ide_wr_n), .ide_d_in(ide_d_in), .ide_d_out(ide_d_out),
    .ide_d_oe(ide_d_oe));

  int checks = 0, fails = 0;
  int rd_pulses = 0, wr_pulses = 0;
  logic [7:0] hold_m = 8'h00;
  logic [7:0]  exp_rsp[$];
  logic [15:0] exp_wr[$];
  int          exp_adr[$];
  bit done = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input int adr, input logic [7:0] d);
    bit ok;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(adr); req_wdata = d;
    forever begin
      ok = req_ready;
      @(negedge clk);
      if (ok) break;
    end
    req_valid = 1'b0;
  endtask

  // Model-side driver: predicts responses, drive addresses and write words
  task automatic host_read(input int adr, input logic [15:0] word);
    if (adr % 2 == 0) begin
      ide_d_in = word;
      exp_adr.push_back(adr / 2);
      exp_rsp.push_back(word[7:0]);
      hold_m = word[15:8];
    end else begin
      exp_rsp.push_back(hold_m);
    end
    do_req(1'b0, adr, 8'h00);
  endtask

  task automatic host_write(input int adr, input logic [7:0] d);
    if (adr % 2 == 0) hold_m = d;
    else begin
      exp_adr.push_back(adr / 2);
      exp_wr.push_back({hold_m, d});
    end
    do_req(1'b1, adr, d);
  endtask

  task automatic settle();
    repeat (PC + 4) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard as the design produces results
  logic prev_cs_n = 1'b1, prev_rd_n = 1'b1, prev_wr_n = 1'b1;
  int low_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid && rsp_ready) begin
        if (exp_rsp.size() == 0) check(0, "R4 unexpected response", rsp_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rsp.pop_front();
          check(rsp_data == e, "R2/R3/R4 response byte", rsp_data, e);
        end
      end
      if (!ide_cs_n && prev_cs_n) begin
        int ea;
        ea = (exp_adr.size() != 0) ? exp_adr.pop_front() : -1;
        check(int'(ide_addr) == ea, "R8 register index", ide_addr, ea);
      end
      if (!ide_rd_n && prev_rd_n) rd_pulses++;
      if (!ide_wr_n && prev_wr_n) begin
        logic [15:0] w;
        wr_pulses++;
        w = (exp_wr.size() != 0) ? exp_wr.pop_front() : 16'hxxxx;
        check(ide_d_out === w && ide_d_oe, "R6 write lanes", ide_d_out, w);
      end
      if (!ide_rd_n || !ide_wr_n) low_len++;
      else if (low_len != 0) begin
        check(low_len == PC, "R2/R6 strobe length", low_len, PC);
        low_len = 0;
      end
      if (!ide_rd_n && !ide_wr_n) check(0, "R7 strobe overlap", 1, 0);
      if (ide_d_oe && ide_wr_n) check(0, "R6 bus driven outside write", 1, 0);
      prev_cs_n = ide_cs_n; prev_rd_n = ide_rd_n; prev_wr_n = ide_wr_n;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int rp, wp;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready && !rsp_valid, "R1 handshake idle", {req_ready, rsp_valid}, 2'b10);
    check(ide_cs_n && ide_rd_n && ide_wr_n && !ide_d_oe, "R1 strobes idle",
          {ide_cs_n, ide_rd_n, ide_wr_n, ide_d_oe}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R6: odd write right after reset carries cleared holding byte
    host_write(1, 8'hA5); settle();
    // R4: odd read after reset returns 0x00 without drive activity
    rp = rd_pulses;
    host_read(5, 16'h0); settle();
    check(rd_pulses == rp, "R4 no strobe on odd read", rd_pulses, rp);

    // R2/R3: even read then odd read
    host_read(0, 16'h1234); settle();
    rp = rd_pulses;
    host_read(1, 16'h0); settle();
    check(rd_pulses == rp, "R3 odd read served from latch", rd_pulses, rp);
    host_read(1, 16'h0); settle();

    // R5: even write loads latch only
    host_read(4, 16'hBEEF); settle();
    rp = rd_pulses; wp = wr_pulses;
    host_write(2, 8'h77); settle();
    check(rd_pulses == rp && wr_pulses == wp, "R5 no strobe on even write",
          rd_pulses + wr_pulses, rp + wp);
    check(!rsp_valid && exp_rsp.size() == 0, "R5 no response", rsp_valid, 0);
    host_write(3, 8'h11); settle();

    // R3: unread high byte replaced by next even read
    host_read(6, 16'hC3A9); settle();
    host_read(8, 16'h5566); settle();
    host_read(9, 16'h0); settle();

    // R8: top of the address range
    host_write(14, 8'h3C); settle();
    host_write(15, 8'hE1); settle();

    // R9: response held back
    rsp_ready = 1'b0;
    host_read(12, 16'hF00D);
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    repeat (5) begin
      @(negedge clk);
      check(rsp_valid && !req_ready && rsp_data == held, "R9 response held",
            {rsp_valid, req_ready, rsp_data}, {2'b10, held});
    end
    rsp_ready = 1'b1;
    settle();
    host_read(13, 16'h0); settle();

    check(exp_rsp.size() == 0 && exp_wr.size() == 0 && exp_adr.size() == 0,
          "R2/R6 scoreboard drained", exp_rsp.size() + exp_wr.size() + exp_adr.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule